// File: doc/BRIEF.md
# Dual-Entry Palette RAM Expander

This block is the colour lookup table of a display pipeline. Software writes 128 raw 32-bit words over a simple synchronous bus. Each word carries two packed colour entries, so the table holds 256 entries in all. A pixel-side port takes an 8-bit colour index and returns that entry as 24-bit RGB, with 8 bits per channel.

Each 16-bit half of a raw word holds three 5-bit channels and an intensity flag. The expander drops the flag and widens each channel to 8 bits by appending three zero bits. The lower half of word n becomes entry 2n and the upper half becomes entry 2n+1. The bus side can read back the raw words unchanged.

Pixel unpacking and the display timing sit outside this block. A reset synchroniser inside the block asserts reset asynchronously and releases it on the clock.

Top module: `pal_ram_expander`

## Requirements
- R1: While reset is asserted, `rd_data` and `px_rgb` are both zero.
- R2: A word written with `wr_en` high at `wr_addr` reads back bit for bit on `rd_data`. The read value appears on the clock edge after `rd_addr` is presented, provided the write edge came earlier.
- R3: Index 2n (`px_index[0]`=0) looks up bits [15:0] of raw word n (`px_index[7:1]`=n).
- R4: Index 2n+1 (`px_index[0]`=1) looks up bits [31:16] of raw word n.
- R5: Within a 16-bit half, red is [4:0], green is [9:5] and blue is [14:10]. These appear on `px_rgb` as red in [23:19], green in [15:11] and blue in [7:3]. Bits [18:16], [10:8] and [2:0] are always zero.
- R6: The intensity bit (bit 15 of each half) has no effect on `px_rgb`.
- R7: `px_rgb` is registered. It shows the entry addressed by `px_index` one clock edge after the index is presented, and holds its value until the next edge.
- R8: When a write and a lookup address the same raw word on the same edge, `px_rgb` returns the old entry on that edge and the new entry on the following one.
- R9: When a write and `rd_addr` address the same word on the same edge, `rd_data` returns the old word on that edge and the new word on the following one.
- R10: With `wr_en` low, values on `wr_addr` and `wr_data` leave the stored words unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Bus write strobe for one word |
| wr_addr | input | 7 | Raw word being written |
| wr_data | input | 32 | Raw palette word to store |
| rd_addr | input | 7 | Raw word to read back |
| rd_data | output | 32 | Registered raw read-back word |
| px_index | input | 8 | Colour index from the pixel pipeline |
| px_rgb | output | 24 | Registered expanded colour {red, green, blue} |

## Verification
Both results are due one clock edge after their address is presented. A write becomes visible to either port one edge after the write edge. The bench therefore drives inputs just after a rising edge and samples on the falling edge that follows the next rising edge. A reference model updates on each rising edge, and it computes its expected outputs from the table as it stood before any write on that edge. This makes the same-edge collision cases fall out of the model directly. Directed checks also sample once before that edge to confirm that `px_rgb` has not moved early. They cover the reset state, the half selection, the channel positions, the ignored intensity bit, and the writes with the strobe low.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int NUM_CH = 3;
  typedef enum int {
    CH_RED   = 0,
    CH_GREEN = 1,
    CH_BLUE  = 2
  } chan_e;
endpackage

// File: rtl/pal_rst_sync.sv
module pal_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pal_store.sv
module pal_store #(
  parameter int WORDS  = 128,
  parameter int WORD_W = 32,
  localparam int AW    = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data,
  input  logic [AW-1:0]     lk_addr,
  output logic [WORD_W-1:0] lk_word
);
  logic [WORD_W-1:0] mem_q [WORDS];
  logic [WORDS-1:0]  word_we;
  logic [WORD_W-1:0] rd_d;

  for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
    assign word_we[gi] = wr_en && (wr_addr == AW'(gi));
    always_ff @(posedge clk) begin
      if (word_we[gi]) mem_q[gi] <= wr_data;
    end
  end

  always_comb begin
    rd_d    = mem_q[rd_addr];
    lk_word = mem_q[lk_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_d;
  end

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem_q[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/pal_expand.sv
module pal_expand
  import pal_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int CH_IN  = 5,
  parameter int CH_OUT = 8,
  localparam int PAD   = CH_OUT - CH_IN,
  localparam int OUT_W = NUM_CH * CH_OUT
) (
  input  logic [HALF_W-1:0] half_i,
  output logic [OUT_W-1:0]  rgb_o
);
  logic unused_intensity;
  assign unused_intensity = ^half_i[HALF_W-1:NUM_CH*CH_IN];

  for (genvar gc = 0; gc < NUM_CH; gc++) begin : g_ch
    assign rgb_o[(NUM_CH-1-gc)*CH_OUT +: CH_OUT] = {half_i[gc*CH_IN +: CH_IN], {PAD{1'b0}}};
  end
endmodule

// File: rtl/pal_lookup.sv
module pal_lookup
  import pal_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CH_IN  = 5,
  parameter int CH_OUT = 8,
  localparam int HALF_W = WORD_W / 2,
  localparam int PAD    = CH_OUT - CH_IN,
  localparam int OUT_W  = NUM_CH * CH_OUT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              odd_sel,
  input  logic [WORD_W-1:0] word_i,
  output logic [OUT_W-1:0]  rgb_q
);
  logic [HALF_W-1:0] half_sel;
  logic [OUT_W-1:0]  rgb_d;

  always_comb begin
    half_sel = odd_sel ? word_i[WORD_W-1:HALF_W] : word_i[HALF_W-1:0];
  end

  pal_expand #(.HALF_W(HALF_W), .CH_IN(CH_IN), .CH_OUT(CH_OUT)) u_expand (
    .half_i (half_sel),
    .rgb_o  (rgb_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rgb_q <= '0;
    else        rgb_q <= rgb_d;
  end

  for (genvar gc = 0; gc < NUM_CH; gc++) begin : g_chk
    p_pad_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rgb_q[gc*CH_OUT +: PAD] == '0);
  end
endmodule

// File: rtl/pal_ram_expander.sv
module pal_ram_expander
  import pal_pkg::*;
#(
  parameter int WORDS  = 128,
  parameter int WORD_W = 32,
  parameter int CH_IN  = 5,
  parameter int CH_OUT = 8,
  localparam int AW    = $clog2(WORDS),
  localparam int IW    = AW + 1,
  localparam int OUT_W = NUM_CH * CH_OUT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data,
  input  logic [IW-1:0]     px_index,
  output logic [OUT_W-1:0]  px_rgb
);
  logic              rst_ni;
  logic [WORD_W-1:0] lk_word;

  pal_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_ni)
  );

  pal_store #(.WORDS(WORDS), .WORD_W(WORD_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_ni),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .lk_addr (px_index[IW-1:1]),
    .lk_word (lk_word)
  );

  pal_lookup #(.WORD_W(WORD_W), .CH_IN(CH_IN), .CH_OUT(CH_OUT)) u_lookup (
    .clk     (clk),
    .rst_n   (rst_ni),
    .odd_sel (px_index[0]),
    .word_i  (lk_word),
    .rgb_q   (px_rgb)
  );

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (!wr_en ##1 (px_index == $past(px_index))) |=> $stable(px_rgb));

  p_rdback_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    ((wr_en && (rd_addr == wr_addr)) ##1 (!wr_en && (rd_addr == $past(rd_addr))))
      |=> (rd_data == $past(wr_data, 2)));
endmodule

// File: tb/pal_ram_expander_test.sv
`timescale 1ns/1ps
module pal_ram_expander_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [6:0]  wr_addr;
  logic [31:0] wr_data;
  logic [6:0]  rd_addr;
  logic [31:0] rd_data;
  logic [7:0]  px_index;
  logic [23:0] px_rgb;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pal_ram_expander uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .px_index(px_index), .px_rgb(px_rgb)
  );

  function automatic logic [23:0] exp_rgb(input logic [15:0] h);
    int r, g, b;
    r = (int'(h) % 32) * 8;
    g = ((int'(h) / 32) % 32) * 8;
    b = ((int'(h) / 1024) % 32) * 8;
    return 24'(r * 65536 + g * 256 + b);
  endfunction

  function automatic logic [31:0] fillv(input int i);
    return (32'(i) * 32'h0100_0193) ^ 32'h8421_5A5A;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  logic [31:0] ref_raw [128];
  bit          ref_ok  [128];
  bit          armed = 0;
  bit          cmp_go = 0;
  bit          px_vld, rd_vld;
  logic [23:0] exp_px;
  logic [31:0] exp_rd;
  logic [31:0] wv;

  initial for (int i = 0; i < 128; i++) ref_ok[i] = 0;

  always @(posedge clk) begin
    cmp_go = armed;
    if (armed) begin
      px_vld = ref_ok[px_index / 2];
      wv = ref_raw[px_index / 2];
      exp_px = exp_rgb(px_index[0] ? wv[31:16] : wv[15:0]);
      rd_vld = ref_ok[rd_addr];
      exp_rd = ref_raw[rd_addr];
      if (wr_en) begin
        ref_raw[wr_addr] = wr_data;
        ref_ok[wr_addr] = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_go && !done) begin
      if (px_vld) check("R7 model px_rgb", {8'h0, px_rgb}, {8'h0, exp_px});
      if (rd_vld) check("R2 model rd_data", rd_data, exp_rd);
    end
  end

  task automatic drive(input logic we, input logic [6:0] wa, input logic [31:0] wd,
                       input logic [6:0] ra, input logic [7:0] pi);
    @(posedge clk); #1;
    wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra; px_index = pi;
  endtask

  task automatic settle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0; px_index = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset rd_data", rd_data, 32'h0);
    check("R1 reset px_rgb", {8'h0, px_rgb}, 32'h0);
    @(posedge clk); #1;
    rst_n = 1;
    repeat (3) @(posedge clk);
    #1 armed = 1;

    // fill all words, reading back and looking up as it goes
    for (int i = 0; i < 128; i++)
      drive(1, 7'(i), fillv(i), 7'((i + 127) % 128), 8'((2 * i + 253) % 256));
    drive(0, 0, 0, 0, 0);
    for (int i = 0; i < 256; i++) drive(0, 7'(i % 128), 32'hDEAD_BEEF, 7'((i * 37) % 128), 8'((i * 59) % 256));

    // channel and half placement
    drive(1, 3, 32'h03E0_001F, 0, 0);
    drive(1, 4, 32'h7C00_FC00, 0, 0);
    drive(0, 0, 0, 3, 6);
    settle();
    check("R3 even half red", {8'h0, px_rgb}, 32'h00F8_0000);
    check("R2 raw readback", rd_data, 32'h03E0_001F);
    drive(0, 0, 0, 4, 7);
    settle();
    check("R4 odd half green", {8'h0, px_rgb}, 32'h0000_F800);
    check("R2 raw readback intensity kept", rd_data, 32'h7C00_FC00);
    drive(0, 0, 0, 4, 8);
    settle();
    check("R6 intensity ignored", {8'h0, px_rgb}, 32'h0000_00F8);
    drive(0, 0, 0, 4, 9);
    settle();
    check("R5 blue position", {8'h0, px_rgb}, 32'h0000_00F8);
    drive(1, 5, 32'h7FFF_FFFF, 0, 0);
    drive(0, 0, 0, 5, 10);
    settle();
    check("R5 pad bits zero", {8'h0, px_rgb}, 32'h00F8_F8F8);
    check("R6 even full vs odd", {8'h0, px_rgb}, {8'h0, exp_rgb(16'h7FFF)});

    // R7 latency: no change before the edge
    drive(0, 0, 0, 0, 6);
    settle();
    @(posedge clk); #1 px_index = 7;
    @(negedge clk);
    check("R7 holds before edge", {8'h0, px_rgb}, 32'h00F8_0000);
    settle();
    check("R7 updates after edge", {8'h0, px_rgb}, 32'h0000_F800);

    // R8 / R9 collisions
    drive(1, 10, 32'h1234_4321, 10, 20);
    settle();
    check("R8 collision old px", {8'h0, px_rgb}, {8'h0, exp_rgb(fillv(10) & 32'hFFFF)});
    check("R9 collision old rd", rd_data, fillv(10));
    wr_en = 0;
    settle();
    check("R8 new px after", {8'h0, px_rgb}, {8'h0, exp_rgb(16'h4321)});
    check("R9 new rd after", rd_data, 32'h1234_4321);

    // R10 write strobe low
    drive(0, 11, 32'hFFFF_FFFF, 11, 23);
    drive(0, 11, 32'hFFFF_FFFF, 11, 23);
    settle();
    check("R10 no write rd", rd_data, fillv(11));
    check("R10 no write px", {8'h0, px_rgb}, {8'h0, exp_rgb(fillv(11) >> 16)});

    // random-ish traffic with model
    for (int i = 0; i < 400; i++)
      drive(((i % 3) == 0), 7'((i * 13) % 128), fillv(i + 500), 7'((i * 13 + (i % 2)) % 128), 8'((i * 26 + (i % 5)) % 256));
    drive(0, 0, 0, 0, 0);
    settle();
    finish_run();
  end
endmodule